// File: doc/BRIEF.md
# Framed four-bit multi-pattern sequence detector

This block watches a serial stream of single bits, one bit per clock cycle in which `in_valid` is high. It cuts the stream into consecutive, non-overlapping frames of four accepted bits. During the first three bits of a frame the match output stays low. On the fourth bit the output goes high in that same cycle if the complete frame is one of the target words 0000, 0011 or 0111. Each word is read left to right in arrival order, so the earliest bit is on the left. After the fourth bit the block returns to its frame-start state whatever the outcome, and the next accepted bit opens a new frame.

The output is Mealy: it is decoded from the stored state together with the bit presented in the current cycle, so a host samples `hit` in the same cycle as the fourth bit. Internally the block is a fully reduced state machine. Frame position and the surviving match prefix are merged into nine states, and all frames that can no longer match share one dead path that runs until the frame boundary.

`arst_n` asserts the reset asynchronously. Its release is synchronised, and bits offered during the first two clock edges after release are not accepted.

Top module: `frame_seq_detect`

## Requirements
- R1: While `arst_n` is low, `hit` is 0 and the machine is held at frame start. The first accepted bit after reset opens a new frame.
- R2: `hit` is 0 on the first, second and third accepted bit of every frame.
- R3: On the fourth accepted bit, `hit` is 1 only if the frame equals 0000, 0011 or 0111 (earliest bit leftmost). For every other frame it is 0.
- R4: Frames are back to back and never overlap. After the fourth accepted bit, the next accepted bit is the first bit of a new frame, whether or not the frame matched.
- R5: In a cycle with `in_valid` low, `hit` is 0 and the frame position and prefix do not change.
- R6: A frame whose first bit is 1 never produces `hit`.
- R7: `hit` responds within the same cycle to `in_bit`. With the prefix 000 stored, changing `in_bit` from 1 to 0 without a clock edge changes `hit` from 0 to 1.
- R8: After `arst_n` rises, bits presented at the first two rising clock edges are ignored. The bit sampled at the third edge is the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial data bit |
| hit | output | 1 | Mealy match flag, valid in the cycle of a frame's fourth bit |

## Verification
All sixteen possible four-bit frames are sent back to back. This separates the three target words from their near neighbours, such as 0001, 0010 and 0110, and from every frame that begins with 1. A long run of zeros shows that a match is reported only on every fourth bit and never at overlapping positions. Streams of random bits with random idle cycles show that gaps neither advance nor disturb the frame position. Sequences around the release of reset, including one reset taken in the middle of a frame, show where the first frame begins. A same-cycle toggle of the last bit shows that the output follows the live input.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int unsigned FRAME_LEN = 4;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned STATE_W   = 4;

  // Reduced machine: position and surviving prefix merged
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 4'd0,  // frame start
    ST_Z     = 4'd1,  // prefix 0
    ST_ZZ    = 4'd2,  // prefix 00
    ST_ZO    = 4'd3,  // prefix 01
    ST_LAST0 = 4'd4,  // prefix 000: a 0 completes a match
    ST_LAST1 = 4'd5,  // prefix 001 or 011: a 1 completes a match
    ST_DEAD1 = 4'd6,  // no match possible, 1 bit consumed
    ST_DEAD2 = 4'd7,  // no match possible, 2 bits consumed
    ST_DEAD3 = 4'd8   // no match possible, 3 bits consumed
  } fd_state_e;
endpackage

// File: rtl/fd_rst_sync.sv
module fd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/fd_next.sv
module fd_next
  import fd_pkg::*;
(
  input  fd_state_e cur,
  input  logic      in_valid,
  input  logic      in_bit,
  output fd_state_e nxt,
  output logic      hit
);
  fd_state_e step_st;
  logic      end_hit;

  always_comb begin
    step_st = ST_IDLE;
    end_hit = 1'b0;
    unique case (cur)
      ST_IDLE:  step_st = in_bit ? ST_DEAD1 : ST_Z;
      ST_Z:     step_st = in_bit ? ST_ZO    : ST_ZZ;
      ST_ZZ:    step_st = in_bit ? ST_LAST1 : ST_LAST0;
      ST_ZO:    step_st = in_bit ? ST_LAST1 : ST_DEAD3;
      ST_DEAD1: step_st = ST_DEAD2;
      ST_DEAD2: step_st = ST_DEAD3;
      ST_LAST0: begin step_st = ST_IDLE; end_hit = ~in_bit; end
      ST_LAST1: begin step_st = ST_IDLE; end_hit = in_bit;  end
      ST_DEAD3: step_st = ST_IDLE;
      default:  step_st = ST_IDLE;
    endcase
  end

  always_comb begin
    nxt = in_valid ? step_st : cur;
    hit = in_valid & end_hit;
  end
endmodule

// File: rtl/fd_state_reg.sv
module fd_state_reg
  import fd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  fd_state_e d,
  output fd_state_e q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= ST_IDLE;
    else if (en) q <= d;
  end
endmodule

// File: rtl/frame_seq_detect.sv
module frame_seq_detect
  import fd_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic hit
);
  logic      rst_n_int;
  fd_state_e state_q;
  fd_state_e state_d;

  fd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_int)
  );

  fd_next u_next (
    .cur      (state_q),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .nxt      (state_d),
    .hit      (hit)
  );

  fd_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (in_valid),
    .d     (state_d),
    .q     (state_q)
  );
endmodule

// File: rtl/fd_checker.sv
module fd_checker
  import fd_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      in_valid,
  input logic      in_bit,
  input logic      hit,
  input fd_state_e state
);
  logic [POS_W-1:0] pos;
  logic             lead_one;

  // independent frame position and leading-bit tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      lead_one <= 1'b0;
    end else if (in_valid) begin
      pos <= pos + 1'b1;
      if (pos == '0) lead_one <= in_bit;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_start: assert (state == ST_IDLE && !hit);
  end

  a_r2_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != POS_W'(FRAME_LEN-1)) |-> !hit);

  a_r3_hit_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (in_valid && pos == POS_W'(FRAME_LEN-1)));

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos == POS_W'(FRAME_LEN-1)) |=> (state == ST_IDLE));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !hit);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state));

  a_r6_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0 && lead_one) |-> !hit);
endmodule

bind frame_seq_detect fd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .in_valid (in_valid),
  .in_bit   (in_bit),
  .hit      (hit),
  .state    (state_q)
);

// File: tb/tb_frame_seq_detect.sv
`timescale 1ns/1ps
module tb_frame_seq_detect;
  logic clk = 1'b0;
  logic arst_n;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic hit;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  string sect = "R1";

  // reference model state
  bit q[$];
  int rel_cnt = 0;

  always #2.5 clk = ~clk;

  frame_seq_detect dut (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_bit(in_bit), .hit(hit)
  );

  function automatic bit active();
    return arst_n && rel_cnt >= 2;
  endfunction

  function automatic bit model_hit(bit v, bit b);
    logic [3:0] w;
    if (!active() || !v || q.size() != 3) return 1'b0;
    w = {q[0], q[1], q[2], b};
    return (w == 4'b0000) || (w == 4'b0011) || (w == 4'b0111);
  endfunction

  function automatic string tag(bit v);
    if (!arst_n) return "R1";
    if (!active()) return "R8";
    if (!v) return "R5";
    if (q.size() < 3) return "R2";
    if (q[0]) return "R6";
    return "R3";
  endfunction

  task automatic compare(bit exp, string t);
    checks++;
    if (hit !== exp) begin
      bad++;
      $display("FAIL %s (%s) t=%0t hit=%b expected=%b", t, sect, $time, hit, exp);
    end
  endtask

  task automatic advance(bit v, bit b);
    if (!arst_n) begin
      rel_cnt = 0;
      q.delete();
    end else begin
      if (rel_cnt >= 2 && v) begin
        q.push_back(b);
        if (q.size() == 4) q.delete();
      end
      if (rel_cnt < 2) rel_cnt++;
    end
  endtask

  task automatic step(bit v, bit b);
    @(negedge clk);
    in_valid = v; in_bit = b;
    #1;
    compare(model_hit(v, b), tag(v));
    @(posedge clk);
    advance(v, b);
  endtask

  task automatic release_step(bit v, bit b);
    @(negedge clk);
    arst_n = 1'b1; in_valid = v; in_bit = b;
    #1;
    compare(model_hit(v, b), "R8");
    @(posedge clk);
    advance(v, b);
  endtask

  task automatic frame(logic [3:0] w);
    for (int i = 3; i >= 0; i--) step(1'b1, w[i]);
  endtask

  initial begin
    arst_n = 1'b1;
    #1 arst_n = 1'b0;
    // R1: reset held with live stimulus
    sect = "R1";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    // R8: bits at the first two edges after release are ignored
    sect = "R8";
    release_step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    frame(4'b0000);
    // R3/R6: all sixteen frames back to back
    sect = "R3";
    for (int w = 0; w < 16; w++) frame(4'(w));
    // R3: stream with expected hits 0000 0001 0001 0001 0000 0001
    frame(4'b1000); frame(4'b0000); frame(4'b0000);
    frame(4'b0111); frame(4'b0101); frame(4'b0011);
    // R4: long zero run, a hit on every fourth bit only
    sect = "R4";
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0);
    frame(4'b1001); frame(4'b0011);
    // R5: idle cycles inside a frame
    sect = "R5";
    step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1);
    step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b1, 1'b1);
    step(1'b0, 1'b0); step(1'b1, 1'b1);
    // R7: same-cycle response to the last bit
    sect = "R7";
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; #1;
    compare(1'b0, "R7");
    in_bit = 1'b0; #1;
    compare(1'b1, "R7");
    @(posedge clk);
    advance(1'b1, 1'b0);
    // R1/R8: reset in the middle of a frame
    sect = "R1";
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    @(negedge clk);
    arst_n = 1'b0; in_valid = 1'b0; #1;
    compare(1'b0, "R1");
    @(posedge clk);
    advance(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    sect = "R8";
    release_step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    frame(4'b0011); frame(4'b0110);
    // random frames with random gaps
    sect = "random";
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 1'($urandom % 2));
    // random frames drawn mostly from the target set
    for (int i = 0; i < 200; i++) begin
      case ($urandom % 4)
        0: frame(4'b0000);
        1: frame(4'b0011);
        2: frame(4'b0111);
        default: frame(4'($urandom % 16));
      endcase
    end
    @(negedge clk);
    in_valid = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule